// File: doc/BRIEF.md
# Circular buffer post-increment address unit

This unit forms the address and the updated pointer for loads that walk a circular buffer. Each request supplies the current pointer, the base of the buffer, a packed modifier word, a signed byte immediate, an access size and a mode bit. The pointer before the update is issued as the access address. The pointer after the update is moved by a signed step and folded back into the window that starts at the base and spans the programmed length.

The modifier word holds the buffer length in its low field. Above that field sits a signed element count. In immediate mode the step is the immediate, counted in bytes. In register mode the step is the element count scaled by the access size. A zero length leaves the pointer where it was and raises a configuration error. Results are registered and appear one cycle after the request.

Top module: `circ_postinc_unit`

## Requirements
- R1: While rst_ni is low, res_valid_o, ea_o, ptr_o and cfg_err_o are all zero.
- R2: res_valid_o is high in exactly the cycle that follows a cycle in which req_valid_i was high.
- R3: For a nonzero length L = mod_i[16:0], ptr_o = start_i + ((ptr_i - start_i + step) mod L), which stays within [start_i, start_i + L). A forward step that passes the end wraps back to the base.
- R4: ea_o is the value of ptr_i before the update.
- R5: When mode_i = 0 (immediate), the step is the signed immediate imm_i in bytes. mod_i[23:17] and size_i have no effect in this mode.
- R6: When mode_i = 1 (register), the step is the signed 7-bit field mod_i[23:17] multiplied by the access size. size_i 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes, and imm_i has no effect in this mode.
- R7: A negative step that would take the pointer below start_i wraps it to start_i + L - (distance below start_i).
- R8: When L = 0, ptr_o equals ptr_i and cfg_err_o is 1. For any nonzero L, cfg_err_o is 0.
- R9: In a cycle with no request, ea_o, ptr_o and cfg_err_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| mode_i | input | 1 | 0 = immediate step, 1 = step from modifier |
| size_i | input | 2 | log2 of the access size in bytes |
| ptr_i | input | 32 | Current pointer |
| start_i | input | 32 | Buffer base address |
| mod_i | input | 24 | Modifier word: [16:0] length, [23:17] signed count |
| imm_i | input | 8 | Signed immediate step in bytes |
| res_valid_o | output | 1 | Result valid |
| ea_o | output | 32 | Access address (pointer before update) |
| ptr_o | output | 32 | Wrapped pointer after update |
| cfg_err_o | output | 1 | Zero-length buffer flagged |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, a 17-bit length field, a 7-bit scaled count and an 8-bit immediate. With these widths every access size can be scaled in register mode, and the most negative count can be driven. Lengths as short as 2 bytes are also reachable, so the pointer wraps on every other access. Chained request sequences exercise forward wraps, backward wraps below the base and zero-length requests. Back-to-back requests and idle gaps exercise the output timing.

// File: rtl/circ_pkg.sv
package circ_pkg;
  typedef enum logic {
    MODE_IMM = 1'b0,
    MODE_REG = 1'b1
  } step_mode_e;
endpackage

// File: rtl/circ_step_sel.sv
module circ_step_sel
  import circ_pkg::*;
#(
  parameter int IMM_W  = 8,
  parameter int INC_W  = 7,
  parameter int SIZE_W = 2,
  parameter int STEP_W = 11
) (
  input  step_mode_e               mode_i,
  input  logic [SIZE_W-1:0]        size_i,
  input  logic [IMM_W-1:0]         imm_i,
  input  logic [INC_W-1:0]         inc_i,
  output logic signed [STEP_W-1:0] step_o
);
  logic signed [STEP_W-1:0] imm_ext;
  logic signed [STEP_W-1:0] inc_ext;

  assign imm_ext = {{(STEP_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign inc_ext = {{(STEP_W-INC_W){inc_i[INC_W-1]}}, inc_i};

  // register mode: count scaled by 2**size
  always_comb begin
    if (mode_i == MODE_REG) step_o = inc_ext <<< size_i;
    else                    step_o = imm_ext;
  end
endmodule

// File: rtl/circ_wrap.sv
module circ_wrap #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 17,
  parameter int STEP_W = 11
) (
  input  logic [ADDR_W-1:0]        ptr_i,
  input  logic [ADDR_W-1:0]        start_i,
  input  logic [LEN_W-1:0]         len_i,
  input  logic signed [STEP_W-1:0] step_i,
  output logic [ADDR_W-1:0]        nxt_o,
  output logic                     err_o
);
  localparam int W = ADDR_W + 1;

  logic [W-1:0] off, stp, ln, sum, fixed;
  logic         below;

  assign off   = {1'b0, ptr_i - start_i};
  assign stp   = {{(W-STEP_W){step_i[STEP_W-1]}}, step_i};
  assign ln    = {{(W-LEN_W){1'b0}}, len_i};
  assign sum   = off + stp;
  assign below = sum[W-1];

  // single correction: |step| < length assumed
  always_comb begin
    if (below)          fixed = sum + ln;
    else if (sum >= ln) fixed = sum - ln;
    else                fixed = sum;
  end

  assign err_o = (len_i == '0);
  assign nxt_o = err_o ? ptr_i : start_i + fixed[ADDR_W-1:0];
endmodule

// File: rtl/circ_postinc_unit.sv
module circ_postinc_unit
  import circ_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 17,
  parameter int INC_W  = 7,
  parameter int IMM_W  = 8,
  parameter int SIZE_W = 2,
  localparam int MOD_W  = LEN_W + INC_W,
  localparam int SCL_W  = INC_W + (1 << SIZE_W) - 1,
  localparam int STEP_W = (IMM_W > SCL_W) ? IMM_W : SCL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              mode_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [MOD_W-1:0]  mod_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic              res_valid_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              cfg_err_o
);
  logic [LEN_W-1:0]         len_w;
  logic [INC_W-1:0]         inc_w;
  logic signed [STEP_W-1:0] step_w;
  logic [ADDR_W-1:0]        nxt_w;
  logic                     err_w;
  logic [ADDR_W-1:0]        len_ext;

  assign len_w   = mod_i[LEN_W-1:0];
  assign inc_w   = mod_i[LEN_W +: INC_W];
  assign len_ext = {{(ADDR_W-LEN_W){1'b0}}, len_w};

  circ_step_sel #(
    .IMM_W (IMM_W),
    .INC_W (INC_W),
    .SIZE_W(SIZE_W),
    .STEP_W(STEP_W)
  ) u_step (
    .mode_i(step_mode_e'(mode_i)),
    .size_i(size_i),
    .imm_i (imm_i),
    .inc_i (inc_w),
    .step_o(step_w)
  );

  circ_wrap #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .STEP_W(STEP_W)
  ) u_wrap (
    .ptr_i  (ptr_i),
    .start_i(start_i),
    .len_i  (len_w),
    .step_i (step_w),
    .nxt_o  (nxt_w),
    .err_o  (err_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      ea_o        <= '0;
      ptr_o       <= '0;
      cfg_err_o   <= 1'b0;
    end else begin
      res_valid_o <= req_valid_i;
      if (req_valid_i) begin
        ea_o      <= ptr_i;
        ptr_o     <= nxt_w;
        cfg_err_o <= err_w;
      end
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o);
  p_ea_is_old_ptr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> ea_o == $past(ptr_i));
  p_ptr_in_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (ptr_i - start_i) < len_ext) |=>
      (cfg_err_o || (ptr_o - $past(start_i)) < $past(len_ext)));
  p_zero_len_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && cfg_err_o) |-> ptr_o == ea_o);
  p_err_iff_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> cfg_err_o == ($past(len_ext) == '0));
  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(ptr_o) && $stable(ea_o) && $stable(cfg_err_o)));
endmodule

// File: tb/sim_circ_postinc_unit.sv
module sim_circ_postinc_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic [31:0] ptr_i = '0, start_i = '0;
  logic [23:0] mod_i = '0;
  logic [7:0]  imm_i = '0;
  logic        res_valid_o, cfg_err_o;
  logic [31:0] ea_o, ptr_o;

  typedef struct {
    logic [31:0] ea;
    logic [31:0] ptr;
    logic        err;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  int          total = 0, bad = 0;
  logic [31:0] cur;
  logic [31:0] last_ptr;
  bit          done = 0;

  always #5 clk = ~clk;

  circ_postinc_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .mode_i(mode_i),
    .size_i(size_i), .ptr_i(ptr_i), .start_i(start_i), .mod_i(mod_i),
    .imm_i(imm_i), .res_valid_o(res_valid_o), .ea_o(ea_o), .ptr_o(ptr_o),
    .cfg_err_o(cfg_err_o)
  );

  function automatic logic [31:0] model(logic [31:0] p, logic [31:0] s,
                                        logic [23:0] m, logic [7:0] im,
                                        logic [1:0] sz, logic md);
    longint len, stp, off, n;
    len = longint'(m[16:0]);
    if (len == 0) return p;
    if (md) stp = longint'($signed(m[23:17])) * (longint'(1) << sz);
    else    stp = longint'($signed(im));
    off = longint'(p - s);
    n = off + stp;
    if (n < 0) n = n + len;
    else if (n >= len) n = n - len;
    return s + 32'(n);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: drives one request and pushes its expected result
  task automatic issue(logic md, logic [1:0] sz, logic [31:0] p, logic [31:0] s,
                       logic [23:0] m, logic [7:0] im, string tag);
    exp_t e;
    @(negedge clk);
    req_valid_i = 1'b1; mode_i = md; size_i = sz; ptr_i = p; start_i = s;
    mod_i = m; imm_i = im;
    e.ea = p; e.ptr = model(p, s, m, im, sz, md); e.err = (m[16:0] == 0);
    e.tag = tag;
    sbq.push_back(e);
    cur = e.ptr;
    last_ptr = e.ptr;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid_i = 1'b0;
      imm_i = 8'h55; mod_i = 24'hABCDEF; ptr_i = 32'hDEAD0000;
    end
  endtask

  function automatic logic [23:0] mk_mod(logic [6:0] inc, logic [16:0] len);
    return {inc, len};
  endfunction

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (rst_ni && !done) begin
        chk(res_valid_o == req_valid_i, "R2 valid timing", 32'(res_valid_o),
            32'(req_valid_i));
        if (res_valid_o) begin
          if (sbq.size() == 0) begin
            chk(0, "R2 unexpected result", 32'(1), 32'(0));
          end else begin
            e = sbq.pop_front();
            chk(ea_o == e.ea, {e.tag, " ea R4"}, ea_o, e.ea);
            chk(ptr_o == e.ptr, {e.tag, " ptr"}, ptr_o, e.ptr);
            chk(cfg_err_o == e.err, {e.tag, " err R8"}, 32'(cfg_err_o), 32'(e.err));
          end
        end
      end
    end
  end

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [31:0] B = 32'h0001_0000;

  initial begin
    repeat (3) @(negedge clk);
    chk({res_valid_o, ea_o, ptr_o, cfg_err_o} == '0, "R1 reset", ptr_o, 0);
    rst_ni = 1'b1;
    idle(2);

    // R5 immediate: len 2, step +1 -> offsets 1,0,1,0 (R3 wrap)
    cur = B;
    for (int i = 0; i < 4; i++) issue(0, 2'd3, cur, B, mk_mod(7'h55, 17'd2), 8'sd1, "R5 R3 imm wrap");
    idle(2);
    // R6 register: halfword, count 1, len 4 -> offsets 2,0,2,0
    cur = B;
    for (int i = 0; i < 4; i++) issue(1, 2'd1, cur, B, mk_mod(7'd1, 17'd4), 8'h7F, "R6 half scaled");
    idle(1);
    // R6 doubleword: count 3 -> 24 bytes, len 40
    cur = B + 32'd20;
    for (int i = 0; i < 3; i++) issue(1, 2'd3, cur, B, mk_mod(7'd3, 17'd40), 8'h00, "R6 dword scaled");
    // R6 byte size, count 5, len 7
    cur = B + 32'd6;
    for (int i = 0; i < 3; i++) issue(1, 2'd0, cur, B, mk_mod(7'd5, 17'd7), 8'h01, "R6 byte scaled");
    idle(1);
    // R7 negative immediate: -3 from offset 1, len 10 -> offset 8
    issue(0, 2'd0, B + 32'd1, B, mk_mod(7'd0, 17'd10), 8'hFD, "R7 neg imm");
    // R7 register negative: word, count -1, len 16 from 0 -> 12
    cur = B;
    for (int i = 0; i < 5; i++) issue(1, 2'd2, cur, B, mk_mod(7'h7F, 17'd16), 8'd0, "R7 neg reg");
    // R7 most negative count -64, byte, len 100, offset 10 -> 46
    issue(1, 2'd0, B + 32'd10, B, mk_mod(7'h40, 17'd100), 8'd0, "R7 min count");
    // R3 step lands exactly on end -> offset 0
    issue(0, 2'd0, B + 32'd5, B, mk_mod(7'd0, 17'd8), 8'd3, "R3 exact end");
    // R5 ignores count field and size: same result with different junk
    issue(0, 2'd0, B + 32'd3, B, mk_mod(7'h3F, 17'd12), 8'd4, "R5 ign a");
    issue(0, 2'd3, B + 32'd3, B, mk_mod(7'h41, 17'd12), 8'd4, "R5 ign b");
    // R8 zero length
    issue(0, 2'd0, B + 32'd7, B, mk_mod(7'd1, 17'd0), 8'd1, "R8 zero len");
    issue(1, 2'd2, B + 32'd9, B, mk_mod(7'd2, 17'd0), 8'd1, "R8 zero len reg");
    issue(0, 2'd0, 32'h0002_0001, 32'h0002_0000, mk_mod(7'd0, 17'h1FFFF), 8'hFF, "R7 max len");
    // R9 hold across idle cycles with toggling inputs
    idle(4);
    chk(ptr_o == last_ptr, "R9 hold ptr", ptr_o, last_ptr);
    chk(ea_o == 32'h0002_0001, "R9 hold ea", ea_o, 32'h0002_0001);
    idle(2);
    chk(sbq.size() == 0, "R2 all results seen", 32'(sbq.size()), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule